// File: doc/BRIEF.md
# Prioritized Interrupt Acknowledge Handler

This block is the servicing side of a backplane priority interrupt scheme. It watches seven shared request lines, of which level 7 is the most urgent and level 1 the least. A mask input selects the subset of levels this instance answers for, so that several handlers can split the levels of one chassis between them. When an enabled level is pending, the handler chooses the highest one and runs an acknowledge cycle. It raises the acknowledge strobe that feeds the first slot of the daisy chain, puts the level number in binary on three address lines, and waits for the responding module to raise data-acknowledge. On that edge it captures the status/ID word from the data lines.

The captured status/ID is handed to a host together with its level through a valid/ready register. The register holds until the host takes it. The handler then removes the strobe, waits for data-acknowledge to fall, and starts again if requests are still pending. This includes further interrupters that hold the same line. If data-acknowledge never arrives, a programmable timeout ends the cycle and reports a bus error.

Top module: `irq_ack_handler`

## Requirements
- R1: Request bit i of `irq_req` (active high) stands for level i+1. When several enabled levels are pending, the highest level is acknowledged first.
- R2: A level whose bit in `level_mask` is 0 is never acknowledged, whether or not it is requested.
- R3: During a cycle `iack_out` is high and `addr_lvl` carries the level number in binary, held constant for the whole cycle. While no cycle runs, `addr_lvl` is 0.
- R4: `data_in` is sampled in the first cycle in which `dtack` is seen high. It appears on `host_status`, with the cycle's level on `host_level`.
- R5: `host_valid`, `host_status` and `host_level` hold until `host_ready` is high. No acknowledge starts while a result is waiting.
- R6: If a serviced line is still asserted, another acknowledge cycle runs on the same level, once for each interrupter holding it.
- R7: After capture the strobe is dropped. A new cycle does not start until `dtack` has gone low.
- R8: If `dtack` does not arrive within `timeout_limit` wait cycles, the strobe is dropped and `bus_err` pulses for one cycle. No result is produced.
- R9: `iack_out` rises two clock edges after an enabled request is seen in idle. `host_valid` rises two edges after the first edge at which the handler is waiting and samples `dtack` high.
- R10: After reset `iack_out`, `addr_lvl`, `host_valid` and `bus_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 7 | Request lines, bit i = level i+1, active high |
| level_mask | input | 7 | Levels this handler services, bit i = level i+1 |
| timeout_limit | input | TO_W | Wait cycles allowed for data-acknowledge |
| iack_out | output | 1 | Acknowledge strobe into the first slot's chain input |
| addr_lvl | output | 3 | Level being acknowledged, binary |
| data_in | input | DATA_W | Status/ID from the data lines |
| dtack | input | 1 | Data-acknowledge from the responder, active high |
| host_valid | output | 1 | Captured result available |
| host_ready | input | 1 | Host accepts the result |
| host_status | output | DATA_W | Captured status/ID |
| host_level | output | 3 | Level the status/ID was taken on |
| bus_err | output | 1 | One-cycle pulse on acknowledge timeout |

## Verification
The strobe is due two edges after a request is seen in idle. The bench checks that it is still low one edge after the request and high one edge later, with the right level on the address lines. A result is due two edges after the waiting handler samples data-acknowledge. The bench samples `host_valid` one nanosecond after each of those two edges and expects it low and then high. The strobe must already be low after the second edge. Bus error, back-pressure and ordering checks are all sampled shortly after a rising edge, so the value compared is the one registered at that edge.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
    localparam int NUM_LEVELS = 7;
    localparam int LVL_W      = $clog2(NUM_LEVELS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_ASSERT,
        ST_WAIT,
        ST_CAPTURE,
        ST_RELEASE
    } ack_state_e;
endpackage

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_ack_pkg::*;
(
    input  logic [NUM_LEVELS-1:0] req,
    output logic                  any,
    output logic [LVL_W-1:0]      lvl
);
    logic [NUM_LEVELS-1:0] above;
    logic [NUM_LEVELS-1:0] winner;

    assign above[NUM_LEVELS-1] = 1'b0;
    for (genvar g = 0; g < NUM_LEVELS - 1; g++) begin : g_chain
        assign above[g] = above[g+1] | req[g+1];
    end
    assign winner = req & ~above;
    assign any    = |req;

    always_comb begin
        lvl = '0;
        for (int i = 0; i < NUM_LEVELS; i++) begin
            if (winner[i]) lvl = LVL_W'(i + 1);
        end
    end
endmodule

// File: rtl/irq_ack_timer.sv
module irq_ack_timer #(
    parameter int TO_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            run,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);
    logic [TO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)                 cnt_d = '0;
        else if (run && ~&cnt_q)   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q >= limit);
endmodule

// File: rtl/irq_result_reg.sv
module irq_result_reg
    import irq_ack_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] status_in,
    input  logic [LVL_W-1:0]  level_in,
    input  logic              ready,
    output logic              valid,
    output logic [DATA_W-1:0] status,
    output logic [LVL_W-1:0]  level
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] st;
        logic [LVL_W-1:0]  lv;
    } res_t;

    res_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (r_q.vld && ready) r_d.vld = 1'b0;
        if (load) begin
            r_d.vld = 1'b1;
            r_d.st  = status_in;
            r_d.lv  = level_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign valid  = r_q.vld;
    assign status = r_q.st;
    assign level  = r_q.lv;
endmodule

// File: rtl/irq_ack_handler.sv
module irq_ack_handler
    import irq_ack_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int TO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        irq_req,
    input  logic [6:0]        level_mask,
    input  logic [TO_W-1:0]   timeout_limit,
    output logic              iack_out,
    output logic [2:0]        addr_lvl,
    input  logic [DATA_W-1:0] data_in,
    input  logic              dtack,
    output logic              host_valid,
    input  logic              host_ready,
    output logic [DATA_W-1:0] host_status,
    output logic [2:0]        host_level,
    output logic              bus_err
);
    typedef struct packed {
        ack_state_e        st;
        logic [LVL_W-1:0]  lvl;
        logic [DATA_W-1:0] cap;
        logic              err;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [NUM_LEVELS-1:0] pending;
    logic                  sel_any;
    logic [LVL_W-1:0]      sel_lvl;
    logic                  tmr_clear;
    logic                  tmr_expired;
    logic                  res_load;

    assign pending = irq_req & level_mask;

    irq_prio_sel u_sel (
        .req (pending),
        .any (sel_any),
        .lvl (sel_lvl)
    );

    irq_ack_timer #(.TO_W(TO_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .run     (c_q.st == ST_WAIT),
        .limit   (timeout_limit),
        .expired (tmr_expired)
    );

    irq_result_reg #(.DATA_W(DATA_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (res_load),
        .status_in (c_q.cap),
        .level_in  (c_q.lvl),
        .ready     (host_ready),
        .valid     (host_valid),
        .status    (host_status),
        .level     (host_level)
    );

    always_comb begin
        c_d       = c_q;
        c_d.err   = 1'b0;
        tmr_clear = 1'b0;
        res_load  = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (!host_valid && !dtack && sel_any) c_d.st = ST_SELECT;
            end
            ST_SELECT: begin
                if (sel_any) begin
                    c_d.lvl = sel_lvl;
                    c_d.st  = ST_ASSERT;
                end else begin
                    c_d.st  = ST_IDLE;
                end
            end
            ST_ASSERT: begin
                tmr_clear = 1'b1;
                c_d.st    = ST_WAIT;
            end
            ST_WAIT: begin
                if (dtack) begin
                    c_d.cap = data_in;
                    c_d.st  = ST_CAPTURE;
                end else if (tmr_expired) begin
                    c_d.err = 1'b1;
                    c_d.st  = ST_IDLE;
                end
            end
            ST_CAPTURE: begin
                res_load = 1'b1;
                c_d.st   = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (!dtack) c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q     <= '0;
            c_q.st  <= ST_IDLE;
        end else begin
            c_q     <= c_d;
        end
    end

    assign iack_out = (c_q.st == ST_ASSERT) || (c_q.st == ST_WAIT) ||
                      (c_q.st == ST_CAPTURE);
    assign addr_lvl = iack_out ? c_q.lvl : '0;
    assign bus_err  = c_q.err;
endmodule

// File: rtl/irq_ack_handler_chk.sv
module irq_ack_handler_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [6:0]        level_mask,
    input logic              iack_out,
    input logic [2:0]        addr_lvl,
    input logic              dtack,
    input logic              host_valid,
    input logic              host_ready,
    input logic [DATA_W-1:0] host_status,
    input logic [2:0]        host_level,
    input logic              bus_err
);
    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_out && $past(iack_out)) |-> $stable(addr_lvl));

    assert_addr_zero_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !iack_out |-> (addr_lvl == 3'd0));

    assert_addr_in_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        iack_out |-> (addr_lvl != 3'd0 && level_mask[addr_lvl - 3'd1]));

    assert_hold_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !host_ready) |=>
        (host_valid && $stable(host_status) && $stable(host_level)));

    assert_no_ack_while_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_valid |-> !iack_out);

    assert_start_after_dtack_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iack_out) |-> !$past(dtack));

    assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> !bus_err);

    assert_err_drops_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> !iack_out);
endmodule

bind irq_ack_handler irq_ack_handler_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .level_mask  (level_mask),
    .iack_out    (iack_out),
    .addr_lvl    (addr_lvl),
    .dtack       (dtack),
    .host_valid  (host_valid),
    .host_ready  (host_ready),
    .host_status (host_status),
    .host_level  (host_level),
    .bus_err     (bus_err)
);

// File: tb/irq_ack_handler_tb_top.sv
`timescale 1ns/1ps
module irq_ack_handler_tb_top;
    localparam int DATA_W = 16;
    localparam int TO_W   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [6:0]        irq_req;
    logic [6:0]        level_mask = 7'h7F;
    logic [TO_W-1:0]   timeout_limit = 8'd40;
    logic              iack_out;
    logic [2:0]        addr_lvl;
    logic [DATA_W-1:0] data_in = '0;
    logic              dtack = 1'b0;
    logic              host_valid;
    logic              host_ready = 1'b0;
    logic [DATA_W-1:0] host_status;
    logic [2:0]        host_level;
    logic              bus_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model of the interrupters on the chain
    int unsigned cnt [7];
    int          resp_dly = 0;
    int          wcnt = 0;
    bit          no_resp = 1'b0;
    bit          hold_dtack = 1'b0;
    logic [7:0]  seq = 8'd0;

    always #2.5 clk = ~clk;

    irq_ack_handler #(.DATA_W(DATA_W), .TO_W(TO_W)) dut_i (
        .clk, .rst_n, .irq_req, .level_mask, .timeout_limit,
        .iack_out, .addr_lvl, .data_in, .dtack,
        .host_valid, .host_ready, .host_status, .host_level, .bus_err
    );

    always_comb begin
        for (int i = 0; i < 7; i++) irq_req[i] = (cnt[i] != 0);
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            dtack = 1'b0;
            wcnt  = 0;
        end else if (iack_out && !dtack) begin
            if (!no_resp && addr_lvl != 3'd0 && cnt[addr_lvl - 1] != 0) begin
                if (wcnt >= resp_dly) begin
                    dtack   = 1'b1;
                    data_in = {5'd0, addr_lvl, seq};
                    seq     = seq + 8'd1;
                    cnt[addr_lvl - 1] = cnt[addr_lvl - 1] - 1;
                    wcnt    = 0;
                end else begin
                    wcnt++;
                end
            end
        end else if (!iack_out && dtack && !hold_dtack) begin
            dtack = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 7; i++) cnt[i] = 0;
    endtask

    // mask, req, dbl (two interrupters), expected first level, expected total
    localparam logic [27:0] VEC [8] = '{
        {7'h7F, 7'h41, 7'h00, 3'd7, 4'd2},
        {7'h7F, 7'h15, 7'h04, 3'd5, 4'd4},
        {7'h0F, 7'h7F, 7'h00, 3'd4, 4'd4},
        {7'h70, 7'h0F, 7'h00, 3'd0, 4'd0},
        {7'h40, 7'h40, 7'h40, 3'd7, 4'd2},
        {7'h2A, 7'h3E, 7'h08, 3'd6, 4'd4},
        {7'h01, 7'h01, 7'h01, 3'd1, 4'd2},
        {7'h55, 7'h7F, 7'h55, 3'd7, 4'd8}
    };

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clear_all();
        repeat (3) tick();
        // R10: reset state
        check(!iack_out, "R10 iack_out", iack_out, 0);
        check(addr_lvl == 0, "R10 addr_lvl", addr_lvl, 0);
        check(!host_valid, "R10 host_valid", host_valid, 0);
        check(!bus_err, "R10 bus_err", bus_err, 0);
        rst_n = 1'b1;
        tick();

        // table of priority / mask / repeat patterns
        host_ready = 1'b1;
        for (int v = 0; v < 8; v++) begin
            logic [27:0] vec;
            int got;
            int first;
            int last;
            bit order_ok;
            bit mask_ok;
            bit id_ok;
            vec = VEC[v];
            level_mask = vec[27:21];
            resp_dly = v % 3;
            for (int i = 0; i < 7; i++)
                cnt[i] = vec[14 + i] ? (vec[7 + i] ? 2 : 1) : 0;
            got = 0; first = 0; last = 8;
            order_ok = 1'b1; mask_ok = 1'b1; id_ok = 1'b1;
            for (int c = 0; c < 250; c++) begin
                tick();
                if (host_valid) begin
                    if (got == 0) first = int'(host_level);
                    if (int'(host_level) > last) order_ok = 1'b0;
                    last = int'(host_level);
                    if (host_level == 0 || !vec[21 + host_level - 1]) mask_ok = 1'b0;
                    if (host_status[10:8] != host_level) id_ok = 1'b0;
                    got++;
                end
            end
            check(first == int'(vec[6:4]), "R1 first level", first, int'(vec[6:4]));
            check(order_ok, "R1 descending order", last, 0);
            check(mask_ok, "R2 only masked levels", int'(level_mask), 0);
            check(got == int'(vec[3:0]), "R6 result count", got, int'(vec[3:0]));
            check(id_ok, "R4 status matches level", 0, 1);
            clear_all();
            tick();
        end

        // R9 / R3 / R7: latency, level encoding and release
        level_mask = 7'h7F;
        resp_dly = 0;
        host_ready = 1'b0;
        hold_dtack = 1'b1;
        cnt[3] = 2;
        tick();
        check(!iack_out, "R9 iack one edge after request", iack_out, 0);
        tick();
        check(iack_out, "R9 iack two edges after request", iack_out, 1);
        check(addr_lvl == 3'd4, "R3 level on address", addr_lvl, 4);
        tick();
        check(iack_out && addr_lvl == 3'd4, "R3 level held", addr_lvl, 4);
        tick();
        check(!host_valid, "R9 valid one edge after dtack", host_valid, 0);
        tick();
        check(host_valid, "R9 valid two edges after dtack", host_valid, 1);
        check(!iack_out, "R7 strobe dropped after capture", iack_out, 0);
        check(host_level == 3'd4, "R4 host level", host_level, 4);
        check(host_status[10:8] == 3'd4, "R4 status captured", host_status[10:8], 4);
        host_ready = 1'b1;
        begin
            bit early;
            early = 1'b0;
            for (int c = 0; c < 10; c++) begin
                tick();
                if (iack_out) early = 1'b1;
            end
            check(!early, "R7 no cycle while dtack high", early, 0);
        end
        hold_dtack = 1'b0;
        begin
            bit seen;
            seen = 1'b0;
            for (int c = 0; c < 30; c++) begin
                tick();
                if (host_valid && host_level == 3'd4) seen = 1'b1;
            end
            check(seen, "R6 second interrupter on level 4", seen, 1);
        end
        clear_all();
        tick();

        // R5: back-pressure
        host_ready = 1'b0;
        cnt[5] = 1;
        cnt[1] = 1;
        begin
            logic [DATA_W-1:0] held;
            bit ok;
            for (int c = 0; c < 40 && !host_valid; c++) tick();
            check(host_valid && host_level == 3'd6, "R5 first result", host_level, 6);
            held = host_status;
            ok = 1'b1;
            for (int c = 0; c < 20; c++) begin
                tick();
                if (!host_valid || host_status != held || host_level != 3'd6 || iack_out)
                    ok = 1'b0;
            end
            check(ok, "R5 result held, no new cycle", ok, 1);
            host_ready = 1'b1;
            tick();
            for (int c = 0; c < 40 && !host_valid; c++) tick();
            check(host_valid && host_level == 3'd2, "R5 next result after ready", host_level, 2);
        end
        clear_all();
        repeat (5) tick();

        // R8: timeout
        timeout_limit = 8'd5;
        no_resp = 1'b1;
        cnt[2] = 1;
        begin
            bit seen;
            bit vld;
            seen = 1'b0;
            vld = 1'b0;
            for (int c = 0; c < 50 && !seen; c++) begin
                tick();
                if (host_valid) vld = 1'b1;
                if (bus_err) seen = 1'b1;
            end
            check(seen, "R8 bus error raised", seen, 1);
            check(!iack_out, "R8 strobe dropped on timeout", iack_out, 0);
            tick();
            check(!bus_err, "R8 bus error one cycle", bus_err, 0);
            check(!vld, "R8 no result on timeout", vld, 0);
        end
        no_resp = 1'b0;
        begin
            bit seen;
            seen = 1'b0;
            for (int c = 0; c < 40; c++) begin
                tick();
                if (host_valid && host_level == 3'd3) seen = 1'b1;
            end
            check(seen, "R8 retry succeeds after timeout", seen, 1);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule